// File: doc/BRIEF.md
# One-Second Error Performance Monitor

This block grades a digital line one second at a time. Three running counters each restart on every one-second tick: one for line code violation pulses, one for bit error pulses and one for bit-period pulses. On each tick the block turns the finished interval into three read-only results. The first is a 16-bit count of violations. The second is an errored-second flag, set if any bit error occurred. The third is a severely-errored-second flag, set if the error ratio was worse than one error per thousand bit periods.

A host reads the latched results over an 8-bit read port at any time. Reads have no side effects. Each result holds the value for the last complete interval until the next tick. The tick source and the line decoder that produces the event pulses are outside the block.

Top module: `err_sec_monitor`

## Requirements
- R1: After a tick, the errored-second flag is 1 if the interval that just closed held at least one bit error pulse, and 0 if it held none.
- R2: After a tick, the severely-errored-second flag is 1 exactly when errors × 1000 > bit periods for the interval that just closed. Equality gives 0. The product is computed without overflow, so 70 errors against 65535 bit periods gives 1.
- R3: Address 0x6D returns the status byte with the errored-second flag in bit 1, the severely-errored-second flag in bit 0 and bits 7:2 equal to 0.
- R4: Address 0x6E returns the high byte and address 0x6F the low byte of the latched 16-bit violation count. Every other address returns 0x00.
- R5: On each tick the running counts are copied into the latched results and the running counters restart. A pulse present in the tick cycle counts toward the new interval, not the one being closed.
- R6: The running violation count saturates at 0xFFFF within an interval and does not wrap.
- R7: Latched results hold their value between ticks, and host reads do not change them.
- R8: During reset, and after reset until the first tick, every address reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse marking the end of a one-second interval |
| err_pulse | input | 1 | One-cycle pulse per detected bit error |
| lcv_pulse | input | 1 | One-cycle pulse per detected line code violation |
| bit_pulse | input | 1 | One-cycle pulse per received bit period |
| rd_addr | input | 8 | Host read address |
| rd_data | output | 8 | Read data for rd_addr, combinational from the latched results |

## Verification
The bench keeps the violation counter at its fixed 16-bit width. It narrows the error counter to 12 bits and the bit-period counter to 16 bits, so one interval of about 70000 cycles drives both the violation count and the bit-period count into saturation. That same interval gives 70 errors against 65535 bit periods. With these values the product of 70000 is the case that a 16-bit product would wrap and misgrade. The equality boundary, 3 errors against 3000 periods, and a tick cycle that carries its own pulses are also run within a short test.

// File: rtl/esm_pkg.sv
package esm_pkg;

  localparam int unsigned REG_BYTE_W = 8;
  localparam int unsigned COUNT_REG_W = 16;
  localparam int unsigned SEVERE_RATIO = 1000;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_STAT = 2'd1,
    SEL_CHI  = 2'd2,
    SEL_CLO  = 2'd3
  } rd_sel_e;

endpackage

// File: rtl/esm_event_counter.sv
module esm_event_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         evt,
  output logic [W-1:0] count
);

  localparam logic [W-1:0] TOP = {W{1'b1}};

  function automatic logic [W-1:0] next_count(input logic [W-1:0] cur,
                                               input logic        ev,
                                               input logic        rs);
    logic [W-1:0] base;
    base = rs ? '0 : cur;
    if (ev && (base != TOP)) return base + 1'b1;
    return base;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= next_count(count, evt, restart);
  end

endmodule

// File: rtl/esm_grader.sv
module esm_grader #(
  parameter int unsigned ERR_W = 24,
  parameter int unsigned BIT_W = 26,
  parameter int unsigned RATIO = esm_pkg::SEVERE_RATIO
) (
  input  logic [ERR_W-1:0] err_count,
  input  logic [BIT_W-1:0] bit_count,
  output logic             errored,
  output logic             severe
);

  localparam int unsigned RATIO_W = $clog2(RATIO + 1);
  localparam int unsigned PROD_W  = ERR_W + RATIO_W;
  localparam int unsigned CMP_W   = ((PROD_W > BIT_W) ? PROD_W : BIT_W) + 1;
  localparam logic [CMP_W-1:0] RATIO_K = CMP_W'(RATIO);

  function automatic logic is_severe(input logic [ERR_W-1:0] e,
                                     input logic [BIT_W-1:0] b);
    logic [CMP_W-1:0] scaled;
    logic [CMP_W-1:0] periods;
    scaled  = CMP_W'(e) * RATIO_K;
    periods = CMP_W'(b);
    return scaled > periods;
  endfunction

  assign errored = (err_count != '0);
  assign severe  = is_severe(err_count, bit_count);

endmodule

// File: rtl/esm_result_regs.sv
module esm_result_regs #(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] ADDR_STAT = 8'h6D,
  parameter logic [ADDR_W-1:0] ADDR_CHI  = 8'h6E,
  parameter logic [ADDR_W-1:0] ADDR_CLO  = 8'h6F
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           tick,
  input  logic [CNT_W-1:0]               lcv_count,
  input  logic                           errored,
  input  logic                           severe,
  input  logic [ADDR_W-1:0]              rd_addr,
  output logic [esm_pkg::REG_BYTE_W-1:0] rd_data,
  output logic [CNT_W-1:0]               held_lcv,
  output logic                           held_es,
  output logic                           held_ses
);
  import esm_pkg::*;

  localparam int unsigned BW = REG_BYTE_W;

  logic [COUNT_REG_W-1:0] lcv_wide;
  rd_sel_e                sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_lcv <= '0;
      held_es  <= 1'b0;
      held_ses <= 1'b0;
    end else if (tick) begin
      held_lcv <= lcv_count;
      held_es  <= errored;
      held_ses <= severe;
    end
  end

  assign lcv_wide = COUNT_REG_W'(held_lcv);

  always_comb begin
    if      (rd_addr == ADDR_STAT) sel = SEL_STAT;
    else if (rd_addr == ADDR_CHI)  sel = SEL_CHI;
    else if (rd_addr == ADDR_CLO)  sel = SEL_CLO;
    else                           sel = SEL_NONE;
  end

  always_comb begin
    unique case (sel)
      SEL_STAT: rd_data = {{(BW-2){1'b0}}, held_es, held_ses};
      SEL_CHI:  rd_data = lcv_wide[COUNT_REG_W-1:BW];
      SEL_CLO:  rd_data = lcv_wide[BW-1:0];
      default:  rd_data = '0;
    endcase
  end

endmodule

// File: rtl/err_sec_monitor.sv
module err_sec_monitor #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ERR_W  = 24,
  parameter int unsigned BIT_W  = 26,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic              err_pulse,
  input  logic              lcv_pulse,
  input  logic              bit_pulse,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);

  logic [CNT_W-1:0] lcv_run;
  logic [ERR_W-1:0] err_run;
  logic [BIT_W-1:0] bit_run;
  logic             grade_es;
  logic             grade_ses;
  logic [CNT_W-1:0] lat_lcv;
  logic             lat_es;
  logic             lat_ses;

  esm_event_counter #(.W(CNT_W)) u_lcv_cnt (
    .clk(clk), .rst_n(rst_n), .restart(sec_tick), .evt(lcv_pulse), .count(lcv_run)
  );

  esm_event_counter #(.W(ERR_W)) u_err_cnt (
    .clk(clk), .rst_n(rst_n), .restart(sec_tick), .evt(err_pulse), .count(err_run)
  );

  esm_event_counter #(.W(BIT_W)) u_bit_cnt (
    .clk(clk), .rst_n(rst_n), .restart(sec_tick), .evt(bit_pulse), .count(bit_run)
  );

  esm_grader #(.ERR_W(ERR_W), .BIT_W(BIT_W)) u_grade (
    .err_count(err_run), .bit_count(bit_run), .errored(grade_es), .severe(grade_ses)
  );

  esm_result_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .tick(sec_tick), .lcv_count(lcv_run),
    .errored(grade_es), .severe(grade_ses), .rd_addr(rd_addr), .rd_data(rd_data),
    .held_lcv(lat_lcv), .held_es(lat_es), .held_ses(lat_ses)
  );

endmodule

// File: rtl/esm_checker.sv
module esm_checker #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ERR_W  = 24,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sec_tick,
  input logic              lcv_pulse,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [7:0]        rd_data,
  input logic [CNT_W-1:0]  lcv_run,
  input logic [ERR_W-1:0]  err_run,
  input logic [CNT_W-1:0]  lat_lcv,
  input logic              lat_es,
  input logic              lat_ses
);

  localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};

  // R1: errors seen before the tick raise the errored flag after it
  a_r1_errored_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && err_run != '0) |=> lat_es);

  // R2: a severe second is always an errored second
  a_r2_severe_implies_errored: assert property (@(posedge clk) disable iff (!rst_n)
    lat_ses |-> lat_es);

  // R3: unused status bits read zero
  a_r3_status_unused: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == ADDR_W'(8'h6D)) |-> (rd_data[7:2] == 6'd0));

  // R5: the tick copies the running count and restarts with the tick-cycle pulse
  a_r5_latch_copy: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> (lat_lcv == $past(lcv_run)));
  a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> (lcv_run == CNT_W'($past(lcv_pulse))));

  // R6: saturation holds, otherwise a pulse adds one
  a_r6_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_tick && lcv_run == SAT) |=> (lcv_run == SAT));
  a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_tick && lcv_pulse && lcv_run != SAT) |=> (lcv_run == $past(lcv_run) + 1'b1));

  // R7: latched results are stable between ticks
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_tick |=> ($stable(lat_lcv) && $stable(lat_es) && $stable(lat_ses)));

endmodule

bind err_sec_monitor esm_checker #(.CNT_W(CNT_W), .ERR_W(ERR_W), .ADDR_W(ADDR_W)) u_esm_chk (
  .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .lcv_pulse(lcv_pulse),
  .rd_addr(rd_addr), .rd_data(rd_data), .lcv_run(lcv_run), .err_run(err_run),
  .lat_lcv(lat_lcv), .lat_es(lat_es), .lat_ses(lat_ses)
);

// File: tb/tb_err_sec_monitor.sv
`timescale 1ns/1ps
module tb_err_sec_monitor;

  localparam int ERR_W = 12;
  localparam int BIT_W = 16;
  localparam longint ERR_MAX = (64'd1 << ERR_W) - 1;
  localparam longint BIT_MAX = (64'd1 << BIT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sec_tick = 1'b0, err_pulse = 1'b0, lcv_pulse = 1'b0, bit_pulse = 1'b0;
  logic [7:0] rd_addr = 8'h00;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  err_sec_monitor #(.ERR_W(ERR_W), .BIT_W(BIT_W)) dut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .err_pulse(err_pulse),
    .lcv_pulse(lcv_pulse), .bit_pulse(bit_pulse), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // behavioural reference
  longint m_lcv, m_err, m_bit;
  longint e_lcv;
  bit     e_es, e_ses;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lcv = 0; m_err = 0; m_bit = 0; e_lcv = 0; e_es = 0; e_ses = 0;
    end else begin
      if (sec_tick) begin
        e_lcv = m_lcv;
        e_es  = (m_err > 0);
        e_ses = (m_err * 1000 > m_bit);
        m_lcv = lcv_pulse ? 1 : 0;
        m_err = err_pulse ? 1 : 0;
        m_bit = bit_pulse ? 1 : 0;
      end else begin
        if (lcv_pulse && m_lcv < 65535)   m_lcv++;
        if (err_pulse && m_err < ERR_MAX) m_err++;
        if (bit_pulse && m_bit < BIT_MAX) m_bit++;
      end
    end
  end

  function automatic logic [7:0] model_read(input logic [7:0] a);
    case (a)
      8'h6D:   return {6'd0, e_es, e_ses};
      8'h6E:   return 8'((e_lcv >> 8) & 255);
      8'h6F:   return 8'(e_lcv & 255);
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_for(input logic [7:0] a);
    case (a)
      8'h6D:   return "R1/R2/R3/R7";
      8'h6E,
      8'h6F:   return "R4/R5/R6/R7";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr=%02h actual=%02h expected=%02h", tag, rd_addr, act, exp);
    end
  endtask

  logic [7:0] addr_ring [4] = '{8'h6D, 8'h6E, 8'h6F, 8'h21};
  int ring_i = 0;

  // one clock of stimulus, then compare against the model
  task automatic cyc(input bit t, input bit e, input bit l, input bit b);
    @(negedge clk);
    sec_tick = t; err_pulse = e; lcv_pulse = l; bit_pulse = b;
    rd_addr = addr_ring[ring_i % 4];
    ring_i++;
    #1 check(tag_for(rd_addr), rd_data, model_read(rd_addr));
  endtask

  // idle cycle reading one address against a fixed expectation
  task automatic rd(input string tag, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk);
    sec_tick = 0; err_pulse = 0; lcv_pulse = 0; bit_pulse = 0;
    rd_addr = a;
    #1 check(tag, rd_data, exp);
    check({tag, " model"}, rd_data, model_read(a));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R8: reads during reset
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      rd_addr = addr_ring[i];
      #1 check("R8 in reset", rd_data, 8'h00);
    end
    @(negedge clk);
    rst_n = 1'b1;
    // R8: events before the first tick leave the results at zero
    for (int i = 0; i < 20; i++) cyc(0, i[0], 1, 1);
    rd("R8 before tick stat", 8'h6D, 8'h00);
    rd("R8 before tick lo", 8'h6F, 8'h00);
    cyc(1, 0, 0, 0);            // close pre-interval

    // interval A: violations only
    for (int i = 0; i < 2000; i++) cyc(0, 0, (i < 10), 1);
    cyc(1, 0, 0, 0);
    rd("R1 no errors", 8'h6D, 8'h00);
    rd("R4 hi byte", 8'h6E, 8'h00);
    rd("R4 lo byte", 8'h6F, 8'h0A);
    rd("R4 other addr", 8'h40, 8'h00);
    rd("R7 reread lo", 8'h6F, 8'h0A);

    // interval B: 3 errors, 3000 periods -> equality, not severe
    for (int i = 0; i < 3000; i++) cyc(0, (i < 3), 0, 1);
    cyc(1, 0, 0, 0);
    rd("R2 equality", 8'h6D, 8'h02);
    rd("R5 lo cleared", 8'h6F, 8'h00);

    // interval C: 3 errors, 2999 periods -> severe
    for (int i = 0; i < 2999; i++) cyc(0, (i < 3), 0, 1);
    cyc(1, 0, 0, 0);
    rd("R2 above ratio", 8'h6D, 8'h03);
    rd("R3 status bits", 8'h6D, 8'h03);

    // tick cycle carrying pulses: they belong to the next interval
    cyc(1, 1, 1, 1);
    rd("R5 tick pulse not in old", 8'h6D, 8'h00);
    rd("R5 tick pulse not in old lo", 8'h6F, 8'h00);
    cyc(1, 0, 0, 0);
    rd("R5 tick pulse in new stat", 8'h6D, 8'h03);
    rd("R5 tick pulse in new lo", 8'h6F, 8'h01);

    // saturation interval and wide product
    for (int i = 0; i < 70000; i++) cyc(0, (i < 70), 1, 1);
    cyc(1, 0, 0, 0);
    rd("R6 saturated hi", 8'h6E, 8'hFF);
    rd("R6 saturated lo", 8'h6F, 8'hFF);
    rd("R2 no overflow", 8'h6D, 8'h03);
    for (int i = 0; i < 50; i++) cyc(0, 0, 0, 0);
    rd("R7 held hi", 8'h6E, 8'hFF);

    // empty interval
    cyc(1, 0, 0, 0);
    rd("R1 empty stat", 8'h6D, 8'h00);
    rd("R4 empty hi", 8'h6E, 8'h00);
    rd("R4 empty lo", 8'h6F, 8'h00);

    finish_run();
  end

endmodule